// File: doc/BRIEF.md
# Duo-Binary Branch Metric Unit

This unit sits at the front of a soft-output decoder for a circular, recursive, systematic convolutional code that carries two information bits per trellis step. On every step it receives four soft channel values: the two systematic bits A and B and the two parity bits Y and W. Each value is a 5-bit sign-magnitude code. It also receives three a priori terms for the information symbols 01, 10 and 11. The term for 00 is the reference and is fixed at zero. From these inputs it forms all sixteen branch metrics, one for every hypothesis of the four coded bits.

Each metric is a correlation sum. Every soft value is added with its own sign when its hypothesised bit is 0 and negated when the bit is 1. The a priori term of the symbol formed by the hypothesised A and B bits is added to that sum. The sixteen sums are then shifted so that the smallest one becomes zero, which gives unsigned 8-bit outputs. The complete set is registered once. It goes out as a write into the branch metric store and, on the same clock cycle, as separate strobes to the a priori update stage and to the circular-state prologue stage. The result appears a fixed two cycles after the input. A symbol index travels with the data and becomes the store address.

Top module: `duobin_bmu`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the store write, the update strobe and the prologue strobe are all low and the metric bus is all zeros.
- R2: An input accepted with `in_valid` high at clock edge k produces the store write at edge k+2, and `st_addr` then equals the `in_idx` given with that input. No write occurs without such an input.
- R3: Metric m sits in bus bits [8m+7:8m]. Bit 3 of m is the hypothesised A, bit 2 is B, bit 1 is Y and bit 0 is W. Before normalisation, the metric is the sum over the four inputs of +v when the hypothesised bit is 0 and -v when it is 1. Here v is the signed value of the input code.
- R4: A soft input code has bit 4 as the sign (1 means negative) and bits 3:0 as the magnitude. The code 10000 (negative zero) gives exactly the same metrics as 00000.
- R5: The a priori inputs are 6-bit two's complement. `apr_01` is added to the metrics with A=0,B=1, `apr_10` to those with A=1,B=0, and `apr_11` to those with A=1,B=1. Metrics with A=0,B=0 receive no a priori term.
- R6: Each output metric equals its pre-normalisation sum minus the smallest of the sixteen sums, so at least one metric of every set is zero.
- R7: The store write, the update strobe and the prologue strobe are asserted on exactly the same cycles, and all three use the same metric bus.
- R8: Inputs may arrive on every cycle without gaps. Each accepted input yields exactly one output set, and the sets come out in input order.
- R9: A cycle with `in_valid` low produces no strobe and leaves the metric bus and `st_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new symbol's soft values are present |
| in_idx | input | 10 | Symbol index, carried to the store address |
| soft_a | input | 5 | Systematic bit A, sign-magnitude |
| soft_b | input | 5 | Systematic bit B, sign-magnitude |
| soft_y | input | 5 | Parity bit Y, sign-magnitude |
| soft_w | input | 5 | Parity bit W, sign-magnitude |
| apr_01 | input | 6 | A priori term for symbol AB=01, two's complement |
| apr_10 | input | 6 | A priori term for symbol AB=10, two's complement |
| apr_11 | input | 6 | A priori term for symbol AB=11, two's complement |
| st_we | output | 1 | Branch metric store write enable |
| st_addr | output | 10 | Branch metric store write address |
| upd_vld | output | 1 | Metric set valid for the a priori update stage |
| pro_vld | output | 1 | Metric set valid for the prologue stage |
| bm_set | output | 128 | Sixteen unsigned 8-bit metrics, metric m in bits [8m+7:8m] |

## Verification
Two functions share a cycle here. One is the store write of a finished set. The other is the capture of the next symbol in the first stage, together with the delivery of that same finished set to both consumers. Long runs with no gaps, each symbol carrying a different pattern, force a write and a capture into every cycle. Each cycle is judged by three things. The three strobes must agree. The address must match the index of the symbol two edges earlier. The bus must match that symbol's arithmetically computed set, with no mixing from its neighbours. Runs with gaps then check that an idle input cycle leaves the previously written set and address untouched.

// File: rtl/duobin_bmu_pkg.sv
package duobin_bmu_pkg;

  localparam int unsigned NUM_MET  = 16;
  localparam int unsigned HYP_BITS = 4;

  // position of each hypothesised bit inside the metric index
  typedef enum int unsigned {
    POS_W = 0,
    POS_Y = 1,
    POS_B = 2,
    POS_A = 3
  } hyp_pos_e;

  // sign-magnitude code of width w to signed integer
  function automatic int sm_decode(input logic [31:0] code, input int unsigned w);
    int mag;
    mag = int'(code & ((32'd1 << (w - 1)) - 32'd1));
    return code[w-1] ? -mag : mag;
  endfunction

  // two's complement value of width w to signed integer
  function automatic int tc_extend(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return v[w-1] ? int'(v | ~mask) : int'(v & mask);
  endfunction

  // correlation contribution of one soft value under a bit hypothesis
  function automatic int corr_term(input int s, input logic hyp);
    return hyp ? -s : s;
  endfunction

endpackage

// File: rtl/bmu_raw_stage.sv
module bmu_raw_stage
  import duobin_bmu_pkg::*;
#(
  parameter int unsigned SOFT_W = 5,
  parameter int unsigned APR_W  = 6,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned RAW_W  = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [IDX_W-1:0]                  in_idx,
  input  logic [SOFT_W-1:0]                 soft_a,
  input  logic [SOFT_W-1:0]                 soft_b,
  input  logic [SOFT_W-1:0]                 soft_y,
  input  logic [SOFT_W-1:0]                 soft_w,
  input  logic [APR_W-1:0]                  apr_01,
  input  logic [APR_W-1:0]                  apr_10,
  input  logic [APR_W-1:0]                  apr_11,
  output logic                              raw_vld,
  output logic [IDX_W-1:0]                  raw_idx,
  output logic [NUM_MET-1:0][RAW_W-1:0]     raw_q
);

  logic [NUM_MET-1:0][RAW_W-1:0] raw_d;
  int va, vb, vy, vw, p01, p10, p11;

  always_comb begin
    va  = sm_decode(32'(soft_a), SOFT_W);
    vb  = sm_decode(32'(soft_b), SOFT_W);
    vy  = sm_decode(32'(soft_y), SOFT_W);
    vw  = sm_decode(32'(soft_w), SOFT_W);
    p01 = tc_extend(32'(apr_01), APR_W);
    p10 = tc_extend(32'(apr_10), APR_W);
    p11 = tc_extend(32'(apr_11), APR_W);
  end

  for (genvar m = 0; m < NUM_MET; m++) begin : g_met
    localparam logic    HA  = 1'((m >> POS_A) & 1);
    localparam logic    HB  = 1'((m >> POS_B) & 1);
    localparam logic    HY  = 1'((m >> POS_Y) & 1);
    localparam logic    HW  = 1'((m >> POS_W) & 1);
    localparam int      SYM = m >> POS_B;
    always_comb begin : c_sum
      int acc;
      acc = corr_term(va, HA) + corr_term(vb, HB)
          + corr_term(vy, HY) + corr_term(vw, HW);
      case (SYM)
        1:       acc = acc + p01;
        2:       acc = acc + p10;
        3:       acc = acc + p11;
        default: acc = acc;
      endcase
      raw_d[m] = RAW_W'(acc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_vld <= 1'b0;
      raw_idx <= '0;
      raw_q   <= '0;
    end else begin
      raw_vld <= in_valid;
      if (in_valid) begin
        raw_idx <= in_idx;
        raw_q   <= raw_d;
      end
    end
  end

endmodule

// File: rtl/bmu_norm_stage.sv
module bmu_norm_stage
  import duobin_bmu_pkg::*;
#(
  parameter int unsigned RAW_W = 9,
  parameter int unsigned OUT_W = 8
) (
  input  logic [NUM_MET-1:0][RAW_W-1:0] raw_in,
  output logic [NUM_MET-1:0][OUT_W-1:0] met_out
);

  localparam int OUT_MAX = (1 << OUT_W) - 1;

  int raw_min;

  always_comb begin
    raw_min = tc_extend(32'(raw_in[0]), RAW_W);
    for (int k = 1; k < NUM_MET; k++) begin
      if (tc_extend(32'(raw_in[k]), RAW_W) < raw_min)
        raw_min = tc_extend(32'(raw_in[k]), RAW_W);
    end
  end

  for (genvar k = 0; k < NUM_MET; k++) begin : g_sub
    always_comb begin : c_sub
      int d;
      d = tc_extend(32'(raw_in[k]), RAW_W) - raw_min;
      met_out[k] = (d > OUT_MAX) ? OUT_W'(OUT_MAX) : OUT_W'(d);
    end
  end

endmodule

// File: rtl/bmu_fanout.sv
module bmu_fanout
  import duobin_bmu_pkg::*;
#(
  parameter int unsigned OUT_W = 8,
  parameter int unsigned IDX_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_vld,
  input  logic [IDX_W-1:0]              set_idx,
  input  logic [NUM_MET-1:0][OUT_W-1:0] set_met,
  output logic                          st_we,
  output logic [IDX_W-1:0]              st_addr,
  output logic                          upd_vld,
  output logic                          pro_vld,
  output logic [NUM_MET*OUT_W-1:0]      bm_set
);

  // one strobe flop per consumer, shared data register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_we   <= 1'b0;
      upd_vld <= 1'b0;
      pro_vld <= 1'b0;
      st_addr <= '0;
      bm_set  <= '0;
    end else begin
      st_we   <= set_vld;
      upd_vld <= set_vld;
      pro_vld <= set_vld;
      if (set_vld) begin
        st_addr <= set_idx;
        bm_set  <= set_met;
      end
    end
  end

endmodule

// File: rtl/duobin_bmu.sv
module duobin_bmu
  import duobin_bmu_pkg::*;
#(
  parameter int unsigned SOFT_W = 5,
  parameter int unsigned APR_W  = 6,
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned IDX_W  = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [IDX_W-1:0]             in_idx,
  input  logic [SOFT_W-1:0]            soft_a,
  input  logic [SOFT_W-1:0]            soft_b,
  input  logic [SOFT_W-1:0]            soft_y,
  input  logic [SOFT_W-1:0]            soft_w,
  input  logic [APR_W-1:0]             apr_01,
  input  logic [APR_W-1:0]             apr_10,
  input  logic [APR_W-1:0]             apr_11,
  output logic                         st_we,
  output logic [IDX_W-1:0]             st_addr,
  output logic                         upd_vld,
  output logic                         pro_vld,
  output logic [NUM_MET*OUT_W-1:0]     bm_set
);

  // widest raw sum: four full-scale soft values plus the largest a priori magnitude
  localparam int unsigned RAW_SPAN = HYP_BITS * (1 << (SOFT_W - 1)) + (1 << (APR_W - 1));
  localparam int unsigned RAW_W    = $clog2(RAW_SPAN) + 2;

  logic                          raw_vld;
  logic [IDX_W-1:0]              raw_idx;
  logic [NUM_MET-1:0][RAW_W-1:0] raw_q;
  logic [NUM_MET-1:0][OUT_W-1:0] norm_met;

  bmu_raw_stage #(
    .SOFT_W (SOFT_W),
    .APR_W  (APR_W),
    .IDX_W  (IDX_W),
    .RAW_W  (RAW_W)
  ) u_raw (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_idx   (in_idx),
    .soft_a   (soft_a),
    .soft_b   (soft_b),
    .soft_y   (soft_y),
    .soft_w   (soft_w),
    .apr_01   (apr_01),
    .apr_10   (apr_10),
    .apr_11   (apr_11),
    .raw_vld  (raw_vld),
    .raw_idx  (raw_idx),
    .raw_q    (raw_q)
  );

  bmu_norm_stage #(
    .RAW_W (RAW_W),
    .OUT_W (OUT_W)
  ) u_norm (
    .raw_in  (raw_q),
    .met_out (norm_met)
  );

  bmu_fanout #(
    .OUT_W (OUT_W),
    .IDX_W (IDX_W)
  ) u_fan (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (raw_vld),
    .set_idx (raw_idx),
    .set_met (norm_met),
    .st_we   (st_we),
    .st_addr (st_addr),
    .upd_vld (upd_vld),
    .pro_vld (pro_vld),
    .bm_set  (bm_set)
  );

endmodule

// File: rtl/duobin_bmu_chk.sv
module duobin_bmu_chk #(
  parameter int unsigned OUT_W = 8,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned N_MET = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [IDX_W-1:0]        in_idx,
  input logic                    st_we,
  input logic [IDX_W-1:0]        st_addr,
  input logic                    upd_vld,
  input logic                    pro_vld,
  input logic [N_MET*OUT_W-1:0]  bm_set
);

  logic zero_seen;
  always_comb begin
    zero_seen = 1'b0;
    for (int k = 0; k < N_MET; k++)
      if (bm_set[k*OUT_W +: OUT_W] == '0) zero_seen = 1'b1;
  end

  AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (st_we == $past(in_valid, 2))); // R2

  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && st_we) |-> (st_addr == $past(in_idx, 2))); // R2

  AST_STROBES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we == upd_vld) && (st_we == pro_vld)); // R7

  AST_MIN_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> zero_seen); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_we && $past(rst_n)) |-> ($stable(bm_set) && $stable(st_addr))); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!st_we && !upd_vld && !pro_vld && bm_set == '0)); // R1

endmodule

bind duobin_bmu duobin_bmu_chk #(
  .OUT_W (OUT_W),
  .IDX_W (IDX_W),
  .N_MET (duobin_bmu_pkg::NUM_MET)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_idx   (in_idx),
  .st_we    (st_we),
  .st_addr  (st_addr),
  .upd_vld  (upd_vld),
  .pro_vld  (pro_vld),
  .bm_set   (bm_set)
);

// File: tb/test_duobin_bmu.sv
`timescale 1ns/1ps
module test_duobin_bmu;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [9:0]   in_idx;
  logic [4:0]   soft_a, soft_b, soft_y, soft_w;
  logic [5:0]   apr_01, apr_10, apr_11;
  logic         st_we, upd_vld, pro_vld;
  logic [9:0]   st_addr;
  logic [127:0] bm_set;

  always #4 clk = ~clk;

  duobin_bmu i_duobin_bmu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
    .soft_a(soft_a), .soft_b(soft_b), .soft_y(soft_y), .soft_w(soft_w),
    .apr_01(apr_01), .apr_10(apr_10), .apr_11(apr_11),
    .st_we(st_we), .st_addr(st_addr), .upd_vld(upd_vld), .pro_vld(pro_vld),
    .bm_set(bm_set)
  );

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  logic [127:0] exp_mem [1024];
  string        tag_mem [1024];
  logic [9:0]   next_idx;
  logic [9:0]   exp_addr;
  logic         d1, d2;
  logic [127:0] last_bus;
  logic [9:0]   last_addr;
  logic         seen_out;
  int           n_in, n_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic int sval(input logic [4:0] c);
    int mag;
    mag = c[3] * 8 + c[2] * 4 + c[1] * 2 + c[0];
    return c[4] ? (0 - mag) : mag;
  endfunction

  function automatic int tval(input logic [5:0] p);
    return (p[5] ? int'(p) - 64 : int'(p));
  endfunction

  function automatic logic [127:0] model(input logic [4:0] a, b, y, w,
                                         input logic [5:0] p1, p2, p3);
    int raw [16];
    int lo;
    logic [127:0] r;
    for (int k = 0; k < 16; k++) begin
      int s;
      s = sval(a) * (1 - 2 * ((k / 8) % 2)) + sval(b) * (1 - 2 * ((k / 4) % 2))
        + sval(y) * (1 - 2 * ((k / 2) % 2)) + sval(w) * (1 - 2 * (k % 2));
      if (k / 4 == 1) s = s + tval(p1);
      if (k / 4 == 2) s = s + tval(p2);
      if (k / 4 == 3) s = s + tval(p3);
      raw[k] = s;
    end
    lo = raw[0];
    for (int k = 1; k < 16; k++) if (raw[k] < lo) lo = raw[k];
    r = '0;
    for (int k = 0; k < 16; k++) r[k*8 +: 8] = 8'(raw[k] - lo);
    return r;
  endfunction

  // one negedge: judge outputs, then drive the next input
  task automatic step(input bit v, input logic [4:0] a, b, y, w,
                      input logic [5:0] p1, p2, p3, input string req);
    @(negedge clk);
    chk(st_we == d2, "R2", "write timing", 128'(st_we), 128'(d2));
    chk(upd_vld == st_we && pro_vld == st_we, "R7", "strobe alignment",
        128'({st_we, upd_vld, pro_vld}), 128'({3{st_we}}));
    if (st_we) begin
      logic zero_any;
      n_out++;
      chk(st_addr == exp_addr, "R8", "output order", 128'(st_addr), 128'(exp_addr));
      chk(bm_set == exp_mem[st_addr], tag_mem[st_addr], "metric set",
          bm_set, exp_mem[st_addr]);
      zero_any = 1'b0;
      for (int k = 0; k < 16; k++) if (bm_set[k*8 +: 8] == 8'd0) zero_any = 1'b1;
      chk(zero_any, "R6", "zero minimum", bm_set, 128'd0);
      exp_addr  = exp_addr + 10'd1;
      last_bus  = bm_set;
      last_addr = st_addr;
      seen_out  = 1'b1;
    end else if (seen_out) begin
      chk(bm_set == last_bus && st_addr == last_addr, "R9", "idle hold",
          {bm_set[117:0], st_addr}, {last_bus[117:0], last_addr});
    end
    d2 = d1;
    d1 = v;
    in_valid = v;
    soft_a = a; soft_b = b; soft_y = y; soft_w = w;
    apr_01 = p1; apr_10 = p2; apr_11 = p3;
    in_idx = next_idx;
    if (v) begin
      exp_mem[next_idx] = model(a, b, y, w, p1, p2, p3);
      tag_mem[next_idx] = req;
      next_idx = next_idx + 10'd1;
      n_in++;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_idx = '0;
    soft_a = '0; soft_b = '0; soft_y = '0; soft_w = '0;
    apr_01 = '0; apr_10 = '0; apr_11 = '0;
    next_idx = '0; exp_addr = '0; d1 = 1'b0; d2 = 1'b0;
    last_bus = '0; last_addr = '0; seen_out = 1'b0; n_in = 0; n_out = 0;
    repeat (4) @(negedge clk);
    // R1: held in reset with a valid input present
    in_valid = 1'b1; soft_a = 5'd9;
    @(negedge clk); @(negedge clk);
    chk(!st_we && !upd_vld && !pro_vld && bm_set == '0, "R1", "reset state",
        {bm_set[124:0], st_we, upd_vld, pro_vld}, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!st_we && !upd_vld && !pro_vld && bm_set == '0, "R1", "after release",
        {bm_set[124:0], st_we, upd_vld, pro_vld}, 128'd0);

    // R3 R8: every A and B code, no gaps, parity and a priori varied
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        step(1'b1, 5'(i), 5'(j), 5'(i * 3 + j), 5'(j * 5 + 7),
             6'(i + j), 6'(i * 2), 6'(j * 7), "R3");

    // R5: every a priori value on each symbol, soft inputs small
    for (int p = 0; p < 64; p++) begin
      step(1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 6'(p), 6'd0, 6'd0, "R5");
      step(1'b1, 5'd3, 5'd17, 5'd0, 5'd0, 6'd0, 6'(p), 6'd0, "R5");
      step(1'b1, 5'd20, 5'd4, 5'd1, 5'd0, 6'd0, 6'd0, 6'(p), "R5");
    end

    // R4: negative zero against positive zero on each input
    step(1'b1, 5'b10000, 5'd5, 5'd21, 5'd2, 6'd3, 6'd60, 6'd9, "R4");
    step(1'b1, 5'd0,     5'd5, 5'd21, 5'd2, 6'd3, 6'd60, 6'd9, "R4");
    step(1'b1, 5'd6, 5'b10000, 5'b10000, 5'b10000, 6'd0, 6'd0, 6'd0, "R4");
    step(1'b1, 5'd6, 5'd0, 5'd0, 5'd0, 6'd0, 6'd0, 6'd0, "R4");

    // R3 R9: every Y and W code, with an idle cycle after each fifth symbol
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) begin
        step(1'b1, 5'(i * 7 + 1), 5'(j * 11), 5'(i), 5'(j),
             6'(j - i), 6'(i * 3 + 1), 6'(40 + j), "R3");
        if (((i * 32 + j) % 5) == 4)
          step(1'b0, 5'd31, 5'd31, 5'd15, 5'd15, 6'd31, 6'd31, 6'd31, "R9");
      end

    // drain
    repeat (4) step(1'b0, 5'd0, 5'd0, 5'd0, 5'd0, 6'd0, 6'd0, 6'd0, "R9");
    chk(n_out == n_in, "R8", "one output per input", 128'(n_out), 128'(n_in));

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule